// File: doc/BRIEF.md
# Task Priority Interrupt Gate

This block holds a programmable task priority threshold and uses it to filter external interrupt requests. There are fifteen priority classes, numbered 1 (lowest) to 15 (highest). Each class has one request line. A class may interrupt only when its number is strictly greater than the threshold. Among the classes that may interrupt, the block reports the highest-numbered one together with a valid flag.

Software changes the threshold through a 64-bit write port. Only the low four bits carry the value. The upper sixty bits are reserved and must be written as zero. A write that sets any reserved bit is refused: the threshold keeps its old value and a one-cycle fault pulse follows. The threshold is always visible on a 64-bit read port, zero-extended. Acknowledge handling, vector delivery and in-service tracking belong to other blocks.

The request and result pins are plain levels, not valid/ready streams. The gate output follows the request lines in the same cycle and never stalls, so there is no back-pressure to handle. A consumer samples `irq_valid` and `irq_class` whenever it is ready.

Top module: `prio_gate_top`

## Requirements
- R1: Bit i of `req_vec` (i = 0..14) is the request of class i+1. `irq_class` encodes a class number as a 4-bit binary value from 1 to 15, and never reports class 0 while `irq_valid` is high.
- R2: With threshold N, a pending class c is blocked when c <= N and passes when c > N. With N = 9, classes 1 to 9 are blocked and classes 10 to 15 pass.
- R3: Threshold 0 lets every pending class through. Threshold 15 blocks every class, so `irq_valid` stays low whatever `req_vec` holds.
- R4: `irq_class` is the highest-numbered class that is both pending and unblocked, and `irq_valid` is high. When no class passes, `irq_valid` is low and `irq_class` is 0. Both outputs follow `req_vec` combinationally.
- R5: While reset (`rst_n` low) is asserted and after it is released, the threshold is 0 and `wr_fault` is low.
- R6: When `wr_en` is high and `wr_data[63:4]` is zero, the threshold takes `wr_data[3:0]` at that clock edge. The gate outputs use the new value from the next cycle on.
- R7: When `wr_en` is high and any bit of `wr_data[63:4]` is set, the threshold keeps its value and `wr_fault` is high for exactly the following cycle. `wr_fault` is low after every other cycle.
- R8: `rd_data[3:0]` always equals the current threshold and `rd_data[63:4]` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vec | input | 15 | Pending requests; bit i is class i+1 |
| wr_en | input | 1 | Threshold write strobe |
| wr_data | input | 64 | Write value; bits 3:0 are the threshold, bits 63:4 are reserved and must be zero |
| rd_data | output | 64 | Current threshold, zero-extended |
| wr_fault | output | 1 | One-cycle pulse after a refused write |
| irq_valid | output | 1 | At least one class passes the gate |
| irq_class | output | 4 | Highest passing class, 0 when none passes |

## Verification
Two events can fall in the same cycle: a threshold write, either accepted or refused, and a change of the request lines. The gate must then use the old threshold with the new requests for that cycle, and the new threshold from the next cycle on. The bench provokes this by changing `req_vec` in the same cycle as good and bad writes. A behavioural model, updated at each rising edge, judges every cycle from the requirement rules. The model is also checked at the thresholds 0, 9 and 15, where every class, a partial band, or no class passes.

// File: rtl/prio_gate_pkg.sv
package prio_gate_pkg;
  localparam int unsigned DEF_DATA_W = 64;
  localparam int unsigned DEF_PRIO_W = 4;

  function automatic int unsigned class_count(input int unsigned prio_w);
    return (1 << prio_w) - 1;
  endfunction
endpackage

// File: rtl/prio_thresh_reg.sv
module prio_thresh_reg #(
  parameter int unsigned DATA_W = prio_gate_pkg::DEF_DATA_W,
  parameter int unsigned PRIO_W = prio_gate_pkg::DEF_PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PRIO_W-1:0] thr_q,
  output logic              fault_q
);
  localparam int unsigned RSV_W = DATA_W - PRIO_W;

  logic [RSV_W-1:0] rsv_bits;
  logic             rsv_dirty;

  assign rsv_bits  = wr_data[DATA_W-1:PRIO_W];
  assign rsv_dirty = |rsv_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_en & rsv_dirty;
      if (wr_en && !rsv_dirty) begin
        thr_q <= wr_data[PRIO_W-1:0];
      end
    end
  end

  AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[DATA_W-1:PRIO_W] != '0)) |=> (fault_q && $stable(thr_q))); // R7

  AST_GOOD_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[DATA_W-1:PRIO_W] == '0)) |=> (!fault_q && thr_q == $past(wr_data[PRIO_W-1:0]))); // R6

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!fault_q && $stable(thr_q))); // R7
endmodule

// File: rtl/prio_mask_gen.sv
module prio_mask_gen #(
  parameter int unsigned PRIO_W = prio_gate_pkg::DEF_PRIO_W,
  parameter int unsigned NCLS   = prio_gate_pkg::class_count(PRIO_W)
) (
  input  logic [PRIO_W-1:0] thr,
  input  logic [NCLS-1:0]   req,
  output logic [NCLS-1:0]   pass
);
  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    localparam logic [PRIO_W-1:0] CLS_NUM = PRIO_W'(g + 1);
    assign pass[g] = req[g] & (CLS_NUM > thr);
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned PRIO_W = prio_gate_pkg::DEF_PRIO_W,
  parameter int unsigned NCLS   = prio_gate_pkg::class_count(PRIO_W)
) (
  input  logic [NCLS-1:0]   pass,
  output logic              any,
  output logic [PRIO_W-1:0] sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (pass[i]) begin
        any = 1'b1;
        sel = PRIO_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/prio_gate_top.sv
module prio_gate_top #(
  parameter int unsigned DATA_W = prio_gate_pkg::DEF_DATA_W,
  parameter int unsigned PRIO_W = prio_gate_pkg::DEF_PRIO_W,
  localparam int unsigned NCLS  = prio_gate_pkg::class_count(PRIO_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLS-1:0]   req_vec,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_fault,
  output logic              irq_valid,
  output logic [PRIO_W-1:0] irq_class
);
  logic [PRIO_W-1:0] thr;
  logic [NCLS-1:0]   pass;

  prio_thresh_reg #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .thr_q   (thr),
    .fault_q (wr_fault)
  );

  prio_mask_gen #(.PRIO_W(PRIO_W), .NCLS(NCLS)) u_mask (
    .thr  (thr),
    .req  (req_vec),
    .pass (pass)
  );

  prio_pick #(.PRIO_W(PRIO_W), .NCLS(NCLS)) u_pick (
    .pass (pass),
    .any  (irq_valid),
    .sel  (irq_class)
  );

  assign rd_data = {{(DATA_W-PRIO_W){1'b0}}, thr};

  AST_WINNER_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_class > rd_data[PRIO_W-1:0] && req_vec[irq_class - 1'b1])); // R2

  AST_NOTHING_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((req_vec >> irq_class) == '0)); // R4

  AST_IDLE_CLASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_class == '0)); // R4

  AST_TOP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[PRIO_W-1:0] == '1) |-> !irq_valid); // R3

  AST_ZERO_PASSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[PRIO_W-1:0] == '0 && req_vec != '0) |-> irq_valid); // R3

  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fault && !$past(wr_en)) |-> 1'b0); // R7
endmodule

// File: tb/prio_gate_top_tb_top.sv
module prio_gate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] req_vec = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        wr_fault;
  logic        irq_valid;
  logic [3:0]  irq_class;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int cyc = 0;
  string tag = "R5";

  int m_thr = 0;
  bit m_fault = 1'b0;

  always #5 clk = ~clk;

  prio_gate_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wr_fault(wr_fault), .irq_valid(irq_valid), .irq_class(irq_class)
  );

  // Behavioural model of the threshold register and fault pulse
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_thr = 0;
      m_fault = 1'b0;
    end else if (wr_en) begin
      if ((wr_data >> 4) != 64'd0) m_fault = 1'b1;
      else begin
        m_thr = int'(wr_data[3:0]);
        m_fault = 1'b0;
      end
    end else m_fault = 1'b0;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string t, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic check_all();
    int best = 0;
    for (int c = 1; c <= 15; c++)
      if (req_vec[c-1] && c > m_thr) best = c;
    chk(tag, "irq_valid", longint'(irq_valid), longint'(best != 0));
    chk(tag, "irq_class", longint'(irq_class), longint'(best));
    chk("R8", "rd_data", longint'(rd_data), longint'(m_thr));
    chk("R7", "wr_fault", longint'(wr_fault), longint'(m_fault));
  endtask

  // advance one cycle and check away from the active edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [63:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    req_vec = 15'h7fff;
    tag = "R5";
    repeat (3) step();
    rst_n = 1'b1;
    repeat (2) step();

    tag = "R1";
    for (int c = 0; c < 15; c++) begin
      req_vec = 15'(1 << c);
      step();
    end

    tag = "R2";
    wr(64'd9);
    for (int c = 0; c < 15; c++) begin
      req_vec = 15'(1 << c);
      step();
    end
    req_vec = 15'h01ff; step();
    req_vec = 15'h0300; step();

    tag = "R3";
    wr(64'd0);
    req_vec = 15'h0001; step();
    req_vec = 15'h7fff; step();
    wr(64'd15);
    for (int c = 0; c < 15; c++) begin
      req_vec = 15'(1 << c);
      step();
    end
    req_vec = 15'h7fff; step();

    tag = "R4";
    for (int t = 0; t < 16; t++) begin
      wr(64'(t));
      for (int k = 0; k < 12; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        req_vec = lfsr[14:0];
        step();
      end
    end
    req_vec = '0; step();

    tag = "R6";
    wr(64'd3);
    req_vec = 15'h0018; wr_en = 1'b1; wr_data = 64'd7;
    step();
    wr_en = 1'b0; wr_data = '0;
    step();
    req_vec = 15'h0100; wr(64'd8);
    step();

    tag = "R7";
    for (int b = 4; b < 64; b += 5) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req_vec = lfsr[14:0];
      wr((64'd1 << b) | 64'd2);
      step();
    end
    wr(64'h8000_0000_0000_0000);
    wr(64'hffff_ffff_ffff_fff0);
    wr(64'd12);
    req_vec = 15'h7000; step();

    tag = "R5";
    rst_n = 1'b0; step();
    rst_n = 1'b1; req_vec = 15'h0001; step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule